// File: doc/BRIEF.md
# Time-Sliced Multi-Port Memory Wrapper

This block gives a slow user-side design many independent memory ports while only one true dual-port RAM sits behind them. The RAM and the wrapper run on a fast memory clock. A start pulse marks the beginning of each user cycle. The wrapper then steps through a fixed schedule of memory-clock slots. In each slot the two physical RAM ports serve a pair of logical ports. When the schedule ends, every logical port has been served. From the user side each logical port looks like a plain synchronous memory port: the inputs are presented for one user cycle and the read result is ready at the end of it.

The schedule has two phases. All reads run first, so a read returns the contents from before the current user cycle. All writes follow, pair by pair, in ascending port order. A larger port count means more slots, and therefore a longer minimum user cycle measured in memory clocks. The user side must keep its port inputs stable from the start pulse until done is raised.

Top module: `tdm_mem_wrapper`

## Requirements
- R1: In slot s of each phase, logical port 2s is served on physical port A and logical port 2s+1 on physical port B. Each phase has P = ceil(N/2) slots, so every one of the N ports gets its read and its write.
- R2: `cyc_done` rises at the 2P-th memory clock edge after the edge that samples `cyc_start`, and it is low before that edge.
- R3: A read always returns the word as it stood before the current user cycle, even when the same or another port writes that address in the same cycle.
- R4: A port's `lp_rdata` field changes only when that port has `lp_rd_en` set in a user cycle. It then stays constant until a later user cycle reads through that port.
- R5: All writes enabled in a user cycle are applied. When several ports write one address in the same cycle, the highest-numbered port's data remains, whether the ports share a slot or not.
- R6: If `cyc_start` arrives while a schedule is still running, `cyc_overrun` is set one edge later and stays set until reset. The schedule restarts from slot 0.
- R7: During and after reset, `cyc_done` and `cyc_overrun` are 0 and every `lp_rdata` field is 0. Reset is applied asynchronously and released after two memory clock edges.
- R8: The edge that samples `cyc_start` clears `cyc_done`.
- R9: Any number of ports may read the same address in one user cycle, and each of them receives that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | One-clock pulse that starts a user cycle |
| lp_rd_en | input | N | Read request per logical port |
| lp_wr_en | input | N | Write request per logical port |
| lp_addr | input | N*AW | Address per logical port; port i uses bits [i*AW +: AW] |
| lp_wdata | input | N*DW | Write data per logical port; port i uses bits [i*DW +: DW] |
| lp_rdata | output | N*DW | Held read data per logical port; port i uses bits [i*DW +: DW] |
| cyc_done | output | 1 | High once the whole slot schedule has finished |
| cyc_overrun | output | 1 | Sticky flag: start arrived before the schedule finished |

## Verification
Count from the edge that samples `cyc_start`. The read issued in slot s reaches its holding register at edge s+2, writes land at edges P+1 through 2P, and `cyc_done` appears after edge 2P. The bench drives and samples on falling edges. It checks that `cyc_done` is low one falling edge before the expected one and high exactly on it. It compares read data only after done, against a model that applies all reads before the writes and the writes in ascending port order. The overrun flag is checked on the falling edge that follows the second start pulse.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  typedef enum logic {PH_READ = 1'b0, PH_WRITE = 1'b1} phase_e;

  function automatic int unsigned pair_count(input int unsigned n);
    return (n + 1) / 2;
  endfunction
endpackage

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
  import tdm_pkg::*;
#(
  parameter int NPAIR = 10,
  parameter int PAW   = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cyc_start,
  output logic           busy,
  output phase_e         phase,
  output logic [PAW-1:0] pair,
  output logic           done,
  output logic           overrun
);
  localparam int NSLOT = 2 * NPAIR;
  localparam int SW    = $clog2(NSLOT + 1);

  logic [SW-1:0] slot_q, slot_d;
  logic          busy_q, busy_d, done_q, done_d, ovr_q, ovr_d;
  logic [SW-1:0] pair_full;

  always_comb begin
    busy_d = busy_q;
    slot_d = slot_q;
    done_d = done_q;
    ovr_d  = ovr_q;
    if (cyc_start) begin
      busy_d = 1'b1;
      slot_d = '0;
      done_d = 1'b0;
      ovr_d  = ovr_q | busy_q;
    end else if (busy_q) begin
      if (slot_q == SW'(NSLOT - 1)) begin
        busy_d = 1'b0;
        slot_d = '0;
        done_d = 1'b1;
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      slot_q <= slot_d;
      done_q <= done_d;
      ovr_q  <= ovr_d;
    end
  end

  always_comb begin
    phase     = (slot_q >= SW'(NPAIR)) ? PH_WRITE : PH_READ;
    pair_full = (phase == PH_WRITE) ? (slot_q - SW'(NPAIR)) : slot_q;
    pair      = pair_full[PAW-1:0];
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign overrun = ovr_q;

  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !done);
  p_busy_not_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && busy) |=> overrun);
  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: rtl/tdm_port_mux.sv
module tdm_port_mux
  import tdm_pkg::*;
#(
  parameter int N     = 20,
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int NPAIR = 10,
  parameter int PAW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  phase_e          phase,
  input  logic [PAW-1:0]  pair,
  input  logic [N-1:0]    lp_rd_en,
  input  logic [N-1:0]    lp_wr_en,
  input  logic [N*AW-1:0] lp_addr,
  input  logic [N*DW-1:0] lp_wdata,
  output logic            a_en,
  output logic            a_we,
  output logic [AW-1:0]   a_addr,
  output logic [DW-1:0]   a_wdata,
  output logic            b_en,
  output logic            b_we,
  output logic [AW-1:0]   b_addr,
  output logic [DW-1:0]   b_wdata
);
  localparam int IW = PAW + 1;

  logic [AW-1:0] addr_arr [N];
  logic [DW-1:0] wdat_arr [N];

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign addr_arr[i] = lp_addr[i*AW +: AW];
    assign wdat_arr[i] = lp_wdata[i*DW +: DW];
  end

  logic [IW-1:0] ai, bi_raw, bi;
  logic          b_valid;

  always_comb begin
    ai      = {pair, 1'b0};
    bi_raw  = {pair, 1'b1};
    b_valid = (int'(bi_raw) < N);
    bi      = b_valid ? bi_raw : '0;
    a_addr  = addr_arr[ai];
    a_wdata = wdat_arr[ai];
    b_addr  = addr_arr[bi];
    b_wdata = wdat_arr[bi];
    a_en    = 1'b0;
    a_we    = 1'b0;
    b_en    = 1'b0;
    b_we    = 1'b0;
    if (busy) begin
      if (phase == PH_READ) begin
        a_en = lp_rd_en[ai];
        b_en = b_valid & lp_rd_en[bi];
      end else begin
        a_we = lp_wr_en[ai];
        b_we = b_valid & lp_wr_en[bi];
        if (a_we && b_we && (a_addr == b_addr)) a_we = 1'b0;
        a_en = a_we;
        b_en = b_we;
      end
    end
  end

  p_no_dual_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && b_we) |-> (a_addr != b_addr));
endmodule

// File: rtl/tdm_dpram.sv
module tdm_dpram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      else      a_rdata     <= mem[a_addr];
    end
    if (b_en) begin
      if (b_we) mem[b_addr] <= b_wdata;
      else      b_rdata     <= mem[b_addr];
    end
  end
endmodule

// File: rtl/tdm_rd_capture.sv
module tdm_rd_capture
  import tdm_pkg::*;
#(
  parameter int N   = 20,
  parameter int DW  = 16,
  parameter int PAW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  phase_e          phase,
  input  logic [PAW-1:0]  pair,
  input  logic [N-1:0]    lp_rd_en,
  input  logic [DW-1:0]   a_rdata,
  input  logic [DW-1:0]   b_rdata,
  output logic [N*DW-1:0] lp_rdata
);
  logic           cap_v_q, cap_v_d;
  logic [PAW-1:0] cap_pair_q, cap_pair_d;

  always_comb begin
    cap_v_d    = busy && (phase == PH_READ);
    cap_pair_d = pair;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_v_q    <= 1'b0;
      cap_pair_q <= '0;
    end else begin
      cap_v_q    <= cap_v_d;
      cap_pair_q <= cap_pair_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_hold
    localparam logic [PAW-1:0] MY_PAIR = PAW'(i / 2);
    logic          load;
    logic [DW-1:0] hold_q, src;

    if ((i % 2) == 0) begin : g_side_a
      assign src = a_rdata;
    end else begin : g_side_b
      assign src = b_rdata;
    end

    assign load = cap_v_q && (cap_pair_q == MY_PAIR) && lp_rd_en[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold_q <= '0;
      else if (load) hold_q <= src;
    end

    assign lp_rdata[i*DW +: DW] = hold_q;
  end
endmodule

// File: rtl/tdm_mem_wrapper.sv
module tdm_mem_wrapper
  import tdm_pkg::*;
#(
  parameter int N  = 20,
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_start,
  input  logic [N-1:0]    lp_rd_en,
  input  logic [N-1:0]    lp_wr_en,
  input  logic [N*AW-1:0] lp_addr,
  input  logic [N*DW-1:0] lp_wdata,
  output logic [N*DW-1:0] lp_rdata,
  output logic            cyc_done,
  output logic            cyc_overrun
);
  localparam int NPAIR = pair_count(N);
  localparam int PAW   = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic           busy;
  phase_e         phase;
  logic [PAW-1:0] pair;
  logic           a_en, a_we, b_en, b_we;
  logic [AW-1:0]  a_addr, b_addr;
  logic [DW-1:0]  a_wdata, b_wdata, a_rdata, b_rdata;

  tdm_slot_seq #(.NPAIR(NPAIR), .PAW(PAW)) u_seq (
    .clk(clk), .rst_n(srst_n), .cyc_start(cyc_start),
    .busy(busy), .phase(phase), .pair(pair),
    .done(cyc_done), .overrun(cyc_overrun)
  );

  tdm_port_mux #(.N(N), .AW(AW), .DW(DW), .NPAIR(NPAIR), .PAW(PAW)) u_mux (
    .clk(clk), .rst_n(srst_n), .busy(busy), .phase(phase), .pair(pair),
    .lp_rd_en(lp_rd_en), .lp_wr_en(lp_wr_en), .lp_addr(lp_addr), .lp_wdata(lp_wdata),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata)
  );

  tdm_dpram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  tdm_rd_capture #(.N(N), .DW(DW), .PAW(PAW)) u_cap (
    .clk(clk), .rst_n(srst_n), .busy(busy), .phase(phase), .pair(pair),
    .lp_rd_en(lp_rd_en), .a_rdata(a_rdata), .b_rdata(b_rdata), .lp_rdata(lp_rdata)
  );

  p_rdata_held_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc_done && !cyc_start) |=> $stable(lp_rdata));
endmodule

// File: tb/sim_tdm_mem_wrapper.sv
module sim_tdm_mem_wrapper;
  localparam int N  = 20;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NS = 2 * ((N + 1) / 2);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cyc_start;
  logic [N-1:0]    rd_m, wr_m;
  logic [AW-1:0]   ad_v [N];
  logic [DW-1:0]   wd_v [N];
  logic [N*AW-1:0] lp_addr;
  logic [N*DW-1:0] lp_wdata, lp_rdata;
  logic            cyc_done, cyc_overrun;

  logic [DW-1:0] mem_m  [1 << AW];
  logic [DW-1:0] hold_m [N];
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      lp_addr[i*AW +: AW]  = ad_v[i];
      lp_wdata[i*DW +: DW] = wd_v[i];
    end
  end

  tdm_mem_wrapper #(.N(N), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .lp_rd_en(rd_m), .lp_wr_en(wr_m), .lp_addr(lp_addr), .lp_wdata(lp_wdata),
    .lp_rdata(lp_rdata), .cyc_done(cyc_done), .cyc_overrun(cyc_overrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_ports();
    rd_m = '0;
    wr_m = '0;
    for (int i = 0; i < N; i++) begin
      ad_v[i] = '0;
      wd_v[i] = '0;
    end
  endtask

  task automatic check_rdata(input string req);
    for (int i = 0; i < N; i++)
      chk(lp_rdata[i*DW +: DW] === hold_m[i], req, 32'(lp_rdata[i*DW +: DW]),
          32'(hold_m[i]));
  endtask

  // One user cycle: model reads first, then writes in ascending port order.
  task automatic run_cycle(input string req);
    for (int i = 0; i < N; i++)
      if (rd_m[i]) hold_m[i] = mem_m[ad_v[i]];
    for (int i = 0; i < N; i++)
      if (wr_m[i]) mem_m[ad_v[i]] = wd_v[i];
    @(negedge clk) cyc_start = 1'b1;
    @(negedge clk) cyc_start = 1'b0;
    chk(cyc_done === 1'b0, "R8 done cleared by start", 32'(cyc_done), 32'd0);
    for (int k = 1; k <= NS; k++) begin
      @(negedge clk);
      if (k == NS - 1)
        chk(cyc_done === 1'b0, "R2 done not early", 32'(cyc_done), 32'd0);
      if (k == NS)
        chk(cyc_done === 1'b1, "R2 done on time", 32'(cyc_done), 32'd1);
    end
    check_rdata(req);
  endtask

  task automatic t_reset();
    chk(cyc_done === 1'b0, "R7 done after reset", 32'(cyc_done), 32'd0);
    chk(cyc_overrun === 1'b0, "R7 overrun after reset", 32'(cyc_overrun), 32'd0);
    check_rdata("R7 rdata after reset");
  endtask

  task automatic t_fill();
    clear_ports();
    for (int i = 0; i < N; i++) begin
      wr_m[i] = 1'b1;
      ad_v[i] = AW'(i);
      wd_v[i] = DW'(16'hA000 + i);
    end
    run_cycle("R5 write-only cycle leaves rdata");
  endtask

  task automatic t_read_all();
    clear_ports();
    for (int i = 0; i < N; i++) begin
      rd_m[i] = 1'b1;
      ad_v[i] = AW'(N - 1 - i);
    end
    run_cycle("R1 every port reads its word");
  endtask

  task automatic t_read_before_write();
    clear_ports();
    for (int i = 0; i < N; i++) begin
      rd_m[i] = 1'b1;
      wr_m[i] = 1'b1;
      ad_v[i] = AW'(i);
      wd_v[i] = DW'(16'h5000 + 3 * i);
    end
    run_cycle("R3 read returns pre-cycle word");
    clear_ports();
    for (int i = 0; i < N; i++) begin
      rd_m[i] = 1'b1;
      ad_v[i] = AW'(i);
    end
    run_cycle("R5 written words visible next cycle");
  endtask

  task automatic t_collide();
    clear_ports();
    wr_m[4] = 1'b1; ad_v[4] = AW'(30); wd_v[4] = 16'h1111;
    wr_m[5] = 1'b1; ad_v[5] = AW'(30); wd_v[5] = 16'h2222;
    wr_m[2] = 1'b1; ad_v[2] = AW'(31); wd_v[2] = 16'h3333;
    wr_m[17] = 1'b1; ad_v[17] = AW'(31); wd_v[17] = 16'h4444;
    run_cycle("R5 colliding writes");
    clear_ports();
    rd_m[0] = 1'b1; ad_v[0] = AW'(30);
    rd_m[1] = 1'b1; ad_v[1] = AW'(31);
    run_cycle("R5 highest port wins");
    chk(hold_m[0] === 16'h2222, "R5 model same-slot winner", 32'(hold_m[0]), 32'h2222);
    chk(hold_m[1] === 16'h4444, "R5 model cross-slot winner", 32'(hold_m[1]), 32'h4444);
  endtask

  task automatic t_partial_hold();
    clear_ports();
    rd_m[3] = 1'b1; ad_v[3] = AW'(7);
    run_cycle("R4 only port 3 updates");
    repeat (6) @(negedge clk);
    check_rdata("R4 rdata held while idle");
  endtask

  task automatic t_broadcast();
    clear_ports();
    for (int i = 0; i < N; i++) begin
      rd_m[i] = 1'b1;
      ad_v[i] = AW'(5);
    end
    run_cycle("R9 all ports read one address");
  endtask

  task automatic t_overrun();
    clear_ports();
    @(negedge clk) cyc_start = 1'b1;
    @(negedge clk) cyc_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(cyc_overrun === 1'b0, "R6 no overrun yet", 32'(cyc_overrun), 32'd0);
    cyc_start = 1'b1;
    @(negedge clk) cyc_start = 1'b0;
    chk(cyc_overrun === 1'b1, "R6 overrun set", 32'(cyc_overrun), 32'd1);
    for (int k = 1; k <= NS; k++) begin
      @(negedge clk);
      if (k == NS - 1)
        chk(cyc_done === 1'b0, "R6 restarted schedule not early", 32'(cyc_done), 32'd0);
    end
    chk(cyc_done === 1'b1, "R6 restarted schedule completes", 32'(cyc_done), 32'd1);
    repeat (4) @(negedge clk);
    chk(cyc_overrun === 1'b1, "R6 overrun sticky", 32'(cyc_overrun), 32'd1);
  endtask

  task automatic apply_reset();
    @(negedge clk) rst_n = 1'b0;
    for (int i = 0; i < N; i++) hold_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cyc_start = 1'b0;
    clear_ports();
    for (int i = 0; i < N; i++) hold_m[i] = '0;
    apply_reset();
    t_reset();
    t_fill();
    t_read_all();
    t_read_before_write();
    t_collide();
    t_partial_hold();
    t_broadcast();
    t_overrun();
    apply_reset();
    t_reset();
    t_read_all();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule